// File: doc/BRIEF.md
# Stack Compare and Relative Branch Unit

This unit resolves the branch opcodes of a byte-coded stack machine. When `start` is high it takes the opcode number, the two topmost stack words, the up to two immediate operand bytes and the current fetch position. It decides whether the branch is taken. It then produces the next fetch position and the number of stack words the opcode consumes. The result is registered and appears one clock later, together with a one-cycle `done` strobe.

A fetch position is a pair. The first part is a quadword base: a word address whose two low bits are zero, because one quadword is four 16-bit words, or eight bytes. The second part is a byte pointer. The absolute byte address is `2*base + ptr`. On input the pointer lies in 0..8 and names the byte that follows the last operand byte already consumed. Every displacement counts from the first byte of the opcode, so the unit first steps back by the opcode length, then adds the displacement. It then splits the sum back into an aligned base and a pointer in 0..7. This can carry into the base or borrow from it by any number of quadwords.

The unit handles fixed short jumps, signed byte and word displacements, equality tests against the second stack word or an immediate, signed and unsigned ordered compares, zero tests, and a nibble-pair compare. An instruction sequencer uses it once per branch opcode and reloads its fetcher from the reported position.

Top module: `stkbr_unit`

## Requirements
- R1: While reset is low, `done`, `taken` and `pop_cnt` are 0, and `out_base` and `out_ptr` are 0. They keep these values until the first `start`.
- R2: Each cycle with `start` high is followed, in the next cycle, by exactly one cycle of `done` high, which carries that opcode's result. In any cycle with `done` low, `taken` and `pop_cnt` are 0.
- R3: Opcode length is 1 byte for codes 0-4, 19, 20, 22 and 23. It is 3 bytes for codes 6, 9 and 10, and 2 bytes for all other defined codes. For a taken branch the target byte is `T = 2*in_base + in_ptr - length + displacement`. The outputs are `out_base = 4*floor(T/8)` (modulo 2^AW words) and `out_ptr = T mod 8`. If `in_base` is a multiple of 4, so is `out_base`.
- R4: Codes 0, 1, 2, 3 and 4 are always taken, with displacements 2, 3, 4, 6 and 8 respectively, and pop 0.
- R5: Code 5 is always taken with the signed displacement `alpha`. Code 6 is always taken with the signed 16-bit displacement `{alpha,beta}`, where `alpha` is the high byte. Both pop 0. A negative displacement lowers the base.
- R6: Code 7 branches when `tos == nos`; code 8 branches when `tos != nos`. Both use the signed displacement `alpha` and pop 2.
- R7: Code 9 branches when `tos` equals `alpha` zero-extended; code 10 branches when they differ. Both use the signed displacement `beta` and pop 1.
- R8: Codes 11, 12, 13 and 14 branch when `nos` is less than, greater or equal to, greater than, or less or equal to `tos`. The comparison is between two's-complement values and must be correct when `nos - tos` overflows. All four use the signed displacement `alpha` and pop 2.
- R9: Codes 15, 16, 17 and 18 make the same four comparisons on unsigned values. They use the signed displacement `alpha` and pop 2.
- R10: Codes 19, 20 and 21 branch when `tos` is 0; codes 22, 23 and 24 branch when it is not. The displacements are 3, 4 and signed `alpha` respectively. All pop 1.
- R11: Code 25 branches when `tos` equals `alpha[7:4]` zero-extended; code 26 branches when they differ. The displacement is `alpha[3:0] + 4` and both pop 1.
- R12: A branch that is not taken reports the fall-through position. The base is `in_base`, plus 4 when `in_ptr` is 8, and the pointer is `in_ptr mod 8`.
- R13: Codes 27 to 31 are never taken, pop 0 and report the fall-through position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Evaluate the opcode presented this cycle |
| opcode | input | 5 | Branch opcode number |
| tos | input | DW | Top stack word |
| nos | input | DW | Second stack word |
| alpha | input | 8 | First immediate byte |
| beta | input | 8 | Second immediate byte |
| in_base | input | AW | Current quadword base (word address) |
| in_ptr | input | 4 | Byte pointer past the consumed operands, 0..8 |
| done | output | 1 | Result valid strobe |
| taken | output | 1 | Branch taken |
| pop_cnt | output | 2 | Stack words consumed |
| out_base | output | AW | New quadword base |
| out_ptr | output | 3 | New byte pointer |

## Verification
The hardest cases lie where the compare and the address arithmetic each hit their edge. One is an ordered compare whose subtraction overflows, such as 0x8000 against 0x0001. Another is a taken branch whose target crosses several quadwords, either backwards below the base or backwards through address zero so that the base wraps. A third is a pointer of 8 combined with a word displacement. Directed vectors place the operands and positions at exactly these values. A generator stream then covers every opcode with stack words that are forced equal about half the time and pointers across the full 0..8 range.

// File: rtl/stkbr_pkg.sv
package stkbr_pkg;

   localparam int OPW = 5;

   typedef enum logic [OPW-1:0] {
      OP_J2   = 5'd0,  OP_J3   = 5'd1,  OP_J4   = 5'd2,  OP_J6   = 5'd3,
      OP_J8   = 5'd4,  OP_JBYT = 5'd5,  OP_JWRD = 5'd6,
      OP_BEQ  = 5'd7,  OP_BNE  = 5'd8,  OP_BEQI = 5'd9,  OP_BNEI = 5'd10,
      OP_BLT  = 5'd11, OP_BGE  = 5'd12, OP_BGT  = 5'd13, OP_BLE  = 5'd14,
      OP_BULT = 5'd15, OP_BUGE = 5'd16, OP_BUGT = 5'd17, OP_BULE = 5'd18,
      OP_BZ3  = 5'd19, OP_BZ4  = 5'd20, OP_BZB  = 5'd21,
      OP_BNZ3 = 5'd22, OP_BNZ4 = 5'd23, OP_BNZB = 5'd24,
      OP_BPEQ = 5'd25, OP_BPNE = 5'd26
   } op_e;

   typedef enum logic [3:0] {
      CK_NEVER, CK_ALWAYS, CK_EQ, CK_NE, CK_LT, CK_GE, CK_GT, CK_LE,
      CK_ULT, CK_UGE, CK_UGT, CK_ULE
   } cond_e;

   typedef enum logic [1:0] { LS_NOS, LS_ALPHA, LS_ZERO, LS_NIB } lhs_e;

   typedef enum logic [2:0] { DS_FIXED, DS_ALPHA, DS_WORD, DS_BETA, DS_NIB } dsel_e;

   typedef struct packed {
      cond_e      cond;
      lhs_e       lhs;
      dsel_e      dsel;
      logic [3:0] fixed;
      logic [1:0] len;
      logic [1:0] pops;
   } dec_t;

endpackage

// File: rtl/stkbr_decode.sv
module stkbr_decode
   import stkbr_pkg::*;
(
   input  logic [OPW-1:0] opcode,
   output dec_t           dec
);

   always_comb begin
      dec = '{cond: CK_NEVER, lhs: LS_NOS, dsel: DS_FIXED,
              fixed: 4'd0, len: 2'd1, pops: 2'd0};
      case (op_e'(opcode))
         OP_J2:   begin dec.cond = CK_ALWAYS; dec.fixed = 4'd2; end
         OP_J3:   begin dec.cond = CK_ALWAYS; dec.fixed = 4'd3; end
         OP_J4:   begin dec.cond = CK_ALWAYS; dec.fixed = 4'd4; end
         OP_J6:   begin dec.cond = CK_ALWAYS; dec.fixed = 4'd6; end
         OP_J8:   begin dec.cond = CK_ALWAYS; dec.fixed = 4'd8; end
         OP_JBYT: begin dec.cond = CK_ALWAYS; dec.dsel = DS_ALPHA; dec.len = 2'd2; end
         OP_JWRD: begin dec.cond = CK_ALWAYS; dec.dsel = DS_WORD;  dec.len = 2'd3; end
         OP_BEQ, OP_BNE: begin
            dec.cond = (op_e'(opcode) == OP_BEQ) ? CK_EQ : CK_NE;
            dec.dsel = DS_ALPHA; dec.len = 2'd2; dec.pops = 2'd2;
         end
         OP_BEQI, OP_BNEI: begin
            dec.cond = (op_e'(opcode) == OP_BEQI) ? CK_EQ : CK_NE;
            dec.lhs  = LS_ALPHA; dec.dsel = DS_BETA; dec.len = 2'd3; dec.pops = 2'd1;
         end
         OP_BLT, OP_BGE, OP_BGT, OP_BLE,
         OP_BULT, OP_BUGE, OP_BUGT, OP_BULE: begin
            case (op_e'(opcode))
               OP_BLT:  dec.cond = CK_LT;
               OP_BGE:  dec.cond = CK_GE;
               OP_BGT:  dec.cond = CK_GT;
               OP_BLE:  dec.cond = CK_LE;
               OP_BULT: dec.cond = CK_ULT;
               OP_BUGE: dec.cond = CK_UGE;
               OP_BUGT: dec.cond = CK_UGT;
               default: dec.cond = CK_ULE;
            endcase
            dec.dsel = DS_ALPHA; dec.len = 2'd2; dec.pops = 2'd2;
         end
         OP_BZ3, OP_BZ4, OP_BZB, OP_BNZ3, OP_BNZ4, OP_BNZB: begin
            dec.lhs  = LS_ZERO; dec.pops = 2'd1;
            dec.cond = (opcode <= 5'(OP_BZB)) ? CK_EQ : CK_NE;
            if (op_e'(opcode) == OP_BZB || op_e'(opcode) == OP_BNZB) begin
               dec.dsel = DS_ALPHA; dec.len = 2'd2;
            end else begin
               dec.fixed = (op_e'(opcode) == OP_BZ3 || op_e'(opcode) == OP_BNZ3) ? 4'd3 : 4'd4;
            end
         end
         OP_BPEQ, OP_BPNE: begin
            dec.cond = (op_e'(opcode) == OP_BPEQ) ? CK_EQ : CK_NE;
            dec.lhs  = LS_NIB; dec.dsel = DS_NIB; dec.len = 2'd2; dec.pops = 2'd1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/stkbr_cond.sv
module stkbr_cond
   import stkbr_pkg::*;
#(
   parameter int DW         = 16,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic [DW-1:0] lhs,
   input  logic [DW-1:0] rhs,
   input  cond_e         cond,
   output logic          hit
);

   logic is_eq, s_lt, u_lt;

   generate
      if (SHARED_SUB) begin : g_shared
         logic [DW:0] diff;
         logic        ovf;
         assign diff  = {1'b0, lhs} - {1'b0, rhs};
         assign ovf   = (lhs[DW-1] != rhs[DW-1]) && (diff[DW-1] != lhs[DW-1]);
         assign s_lt  = diff[DW-1] ^ ovf;
         assign u_lt  = diff[DW];
         assign is_eq = (diff[DW-1:0] == '0);
      end else begin : g_direct
         assign s_lt  = $signed(lhs) < $signed(rhs);
         assign u_lt  = lhs < rhs;
         assign is_eq = lhs == rhs;
      end
   endgenerate

   always_comb begin
      case (cond)
         CK_ALWAYS: hit = 1'b1;
         CK_EQ:     hit = is_eq;
         CK_NE:     hit = !is_eq;
         CK_LT:     hit = s_lt;
         CK_GE:     hit = !s_lt;
         CK_GT:     hit = !s_lt && !is_eq;
         CK_LE:     hit = s_lt || is_eq;
         CK_ULT:    hit = u_lt;
         CK_UGE:    hit = !u_lt;
         CK_UGT:    hit = !u_lt && !is_eq;
         CK_ULE:    hit = u_lt || is_eq;
         default:   hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/stkbr_target.sv
module stkbr_target #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic [AW-1:0] base,
   input  logic [3:0]    ptr,
   input  logic [1:0]    len,
   input  logic [DW-1:0] disp,
   output logic [AW-1:0] tgt_base,
   output logic [2:0]    tgt_ptr,
   output logic [AW-1:0] ft_base,
   output logic [2:0]    ft_ptr
);

   localparam int XW = ((AW > DW) ? AW : DW) + 5;

   logic signed [XW-1:0] off;
   logic        [AW-1:0] delta;

   // byte offset of the target from the start of the current quadword
   assign off      = XW'($signed(disp)) + $signed(XW'(ptr)) - $signed(XW'(len));
   assign delta    = AW'(off >>> 3) << 2;
   assign tgt_base = base + delta;
   assign tgt_ptr  = off[2:0];

   assign ft_base  = ptr[3] ? base + AW'(4) : base;
   assign ft_ptr   = ptr[2:0];

endmodule

// File: rtl/stkbr_unit.sv
module stkbr_unit
   import stkbr_pkg::*;
#(
   parameter int DW         = 16,
   parameter int AW         = 16,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [4:0]     opcode,
   input  logic [DW-1:0]  tos,
   input  logic [DW-1:0]  nos,
   input  logic [7:0]     alpha,
   input  logic [7:0]     beta,
   input  logic [AW-1:0]  in_base,
   input  logic [3:0]     in_ptr,
   output logic           done,
   output logic           taken,
   output logic [1:0]     pop_cnt,
   output logic [AW-1:0]  out_base,
   output logic [2:0]     out_ptr
);

   generate
      if (DW < 16) begin : g_bad_dw
         $error("stkbr_unit: DW must hold a 16-bit word displacement");
      end
      if (AW < 3) begin : g_bad_aw
         $error("stkbr_unit: AW must cover at least one quadword step");
      end
   endgenerate

   dec_t          dec;
   logic [DW-1:0] lhs, disp;
   logic          hit;
   logic [AW-1:0] tgt_base, ft_base;
   logic [2:0]    tgt_ptr, ft_ptr;

   stkbr_decode u_dec (.opcode(opcode), .dec(dec));

   always_comb begin
      case (dec.lhs)
         LS_ALPHA: lhs = DW'(alpha);
         LS_ZERO:  lhs = '0;
         LS_NIB:   lhs = DW'(alpha[7:4]);
         default:  lhs = nos;
      endcase
   end

   always_comb begin
      case (dec.dsel)
         DS_ALPHA: disp = DW'($signed(alpha));
         DS_WORD:  disp = DW'($signed({alpha, beta}));
         DS_BETA:  disp = DW'($signed(beta));
         DS_NIB:   disp = DW'({1'b0, alpha[3:0]} + 5'd4);
         default:  disp = DW'(dec.fixed);
      endcase
   end

   stkbr_cond #(.DW(DW), .SHARED_SUB(SHARED_SUB)) u_cond (
      .lhs(lhs), .rhs(tos), .cond(dec.cond), .hit(hit)
   );

   stkbr_target #(.AW(AW), .DW(DW)) u_tgt (
      .base(in_base), .ptr(in_ptr), .len(dec.len), .disp(disp),
      .tgt_base(tgt_base), .tgt_ptr(tgt_ptr), .ft_base(ft_base), .ft_ptr(ft_ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done     <= 1'b0;
         taken    <= 1'b0;
         pop_cnt  <= 2'd0;
         out_base <= '0;
         out_ptr  <= '0;
      end else if (start) begin
         done     <= 1'b1;
         taken    <= hit;
         pop_cnt  <= dec.pops;
         out_base <= hit ? tgt_base : ft_base;
         out_ptr  <= hit ? tgt_ptr  : ft_ptr;
      end else begin
         done     <= 1'b0;
         taken    <= 1'b0;
         pop_cnt  <= 2'd0;
      end
   end

   AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);                                                          // R2
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);                                                        // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!taken && pop_cnt == 2'd0));                                   // R2
   AST_QUAD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && in_base[1:0] == 2'b00) |=> (out_base[1:0] == 2'b00));           // R3
   AST_FIXED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && opcode <= 5'd6) |=> (taken && pop_cnt == 2'd0));                // R4
   AST_ZERO_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && opcode >= 5'd19 && opcode <= 5'd24) |=> (pop_cnt == 2'd1));     // R10
   AST_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !hit) |=> (out_base == $past(ft_base) && out_ptr == $past(ft_ptr))); // R12
   AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (start && opcode >= 5'd27) |=> (!taken && pop_cnt == 2'd0));              // R13

endmodule

// File: tb/stkbr_unit_test.sv
module stkbr_unit_test;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic        taken;
      logic [1:0]  pop;
      logic [15:0] base;
      logic [2:0]  ptr;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  opcode = '0;
   logic [15:0] tos = '0, nos = '0;
   logic [7:0]  alpha = '0, beta = '0;
   logic [15:0] in_base = '0;
   logic [3:0]  in_ptr = '0;
   logic        done, taken;
   logic [1:0]  pop_cnt;
   logic [15:0] out_base;
   logic [2:0]  out_ptr;

   int   checks = 0;
   int   errors = 0;
   bit   reported = 1'b0;
   exp_t sb[$];
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #(CLK_PERIOD/2) clk = ~clk;

   stkbr_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .tos(tos), .nos(nos), .alpha(alpha), .beta(beta),
      .in_base(in_base), .in_ptr(in_ptr),
      .done(done), .taken(taken), .pop_cnt(pop_cnt),
      .out_base(out_base), .out_ptr(out_ptr)
   );

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   function automatic exp_t model(input logic [4:0] op, input logic [15:0] t, n,
                                  input logic [7:0] a, b, input logic [15:0] bs,
                                  input logic [3:0] p, input string tag);
      exp_t   e;
      int     len, d;
      bit     c;
      longint pos, tg;
      int     sa;
      len = 1; d = 0; c = 1'b0; e.pop = 2'd0; e.tag = tag;
      sa = $signed(a);
      case (op)
         5'd0: begin c = 1; d = 2; end
         5'd1: begin c = 1; d = 3; end
         5'd2: begin c = 1; d = 4; end
         5'd3: begin c = 1; d = 6; end
         5'd4: begin c = 1; d = 8; end
         5'd5: begin c = 1; d = sa; len = 2; end
         5'd6: begin c = 1; d = $signed({a, b}); len = 3; end
         5'd7, 5'd8: begin
            len = 2; e.pop = 2; d = sa;
            c = (op == 5'd7) ? (t == n) : (t != n);
         end
         5'd9, 5'd10: begin
            len = 3; e.pop = 1; d = $signed(b);
            c = (op == 5'd9) ? (t == {8'h00, a}) : (t != {8'h00, a});
         end
         5'd11: begin len = 2; e.pop = 2; d = sa; c = $signed(n) <  $signed(t); end
         5'd12: begin len = 2; e.pop = 2; d = sa; c = $signed(n) >= $signed(t); end
         5'd13: begin len = 2; e.pop = 2; d = sa; c = $signed(n) >  $signed(t); end
         5'd14: begin len = 2; e.pop = 2; d = sa; c = $signed(n) <= $signed(t); end
         5'd15: begin len = 2; e.pop = 2; d = sa; c = n <  t; end
         5'd16: begin len = 2; e.pop = 2; d = sa; c = n >= t; end
         5'd17: begin len = 2; e.pop = 2; d = sa; c = n >  t; end
         5'd18: begin len = 2; e.pop = 2; d = sa; c = n <= t; end
         5'd19: begin e.pop = 1; d = 3; c = (t == 0); end
         5'd20: begin e.pop = 1; d = 4; c = (t == 0); end
         5'd21: begin e.pop = 1; d = sa; len = 2; c = (t == 0); end
         5'd22: begin e.pop = 1; d = 3; c = (t != 0); end
         5'd23: begin e.pop = 1; d = 4; c = (t != 0); end
         5'd24: begin e.pop = 1; d = sa; len = 2; c = (t != 0); end
         5'd25, 5'd26: begin
            len = 2; e.pop = 1; d = int'(a[3:0]) + 4;
            c = (op == 5'd25) ? (t == {12'h000, a[7:4]}) : (t != {12'h000, a[7:4]});
         end
         default: ;
      endcase
      pos = longint'(bs) * 2 + longint'(p);
      tg  = c ? pos - len + d : pos;
      e.taken = c;
      e.base  = 16'((tg >>> 3) * 4);
      e.ptr   = 3'(tg & 7);
      return e;
   endfunction

   task automatic send(input logic [4:0] op, input logic [15:0] t, n,
                       input logic [7:0] a, b, input logic [15:0] bs,
                       input logic [3:0] p, input string tag);
      @(negedge clk);
      opcode = op; tos = t; nos = n; alpha = a; beta = b;
      in_base = bs; in_ptr = p; start = 1'b1;
      sb.push_back(model(op, t, n, a, b, bs, p, tag));
      @(negedge clk);
      start = 1'b0;
   endtask

   function automatic logic [31:0] step(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   // monitor: compare each result against the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
               errors++;
               $display("FAIL R2: done with no pending opcode (taken=%0b)", taken);
            end else begin
               e = sb.pop_front();
               if (taken !== e.taken || pop_cnt !== e.pop ||
                   out_base !== e.base || out_ptr !== e.ptr) begin
                  errors++;
                  $display("FAIL %s: got taken=%0b pop=%0d base=%h ptr=%0d, expected taken=%0b pop=%0d base=%h ptr=%0d",
                           e.tag, taken, pop_cnt, out_base, out_ptr,
                           e.taken, e.pop, e.base, e.ptr);
               end
            end
         end else if (taken !== 1'b0 || pop_cnt !== 2'd0) begin
            checks++;
            errors++;
            $display("FAIL R2: idle cycle shows taken=%0b pop=%0d, expected 0 and 0", taken, pop_cnt);
         end
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;                                                  // R1 reset state
      if (done !== 1'b0 || taken !== 1'b0 || pop_cnt !== 2'd0 ||
          out_base !== 16'h0 || out_ptr !== 3'd0) begin
         errors++;
         $display("FAIL R1: got done=%0b taken=%0b pop=%0d base=%h ptr=%0d, expected all 0",
                  done, taken, pop_cnt, out_base, out_ptr);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (done !== 1'b0 || out_base !== 16'h0) begin
         errors++;
         $display("FAIL R1: after release done=%0b base=%h, expected 0 and 0000", done, out_base);
      end

      // R4 fixed jumps
      send(5'd0, 16'h0, 16'h0, 8'h00, 8'h00, 16'h0100, 4'd1, "R4");
      send(5'd1, 16'h0, 16'h0, 8'h00, 8'h00, 16'h0100, 4'd7, "R4");
      send(5'd2, 16'h0, 16'h0, 8'h00, 8'h00, 16'h0100, 4'd8, "R4");
      send(5'd3, 16'h0, 16'h0, 8'h00, 8'h00, 16'h0100, 4'd5, "R4");
      send(5'd3, 16'h0, 16'h0, 8'h00, 8'h00, 16'h0100, 4'd1, "R4");
      send(5'd4, 16'h0, 16'h0, 8'h00, 8'h00, 16'h0100, 4'd8, "R4");
      // R5 byte and word displacements, with borrow and wrap
      send(5'd5, 16'h0, 16'h0, 8'h80, 8'h00, 16'h0100, 4'd2, "R5");
      send(5'd5, 16'h0, 16'h0, 8'h7F, 8'h00, 16'h0100, 4'd8, "R5");
      send(5'd5, 16'h0, 16'h0, 8'hFE, 8'h00, 16'h0000, 4'd1, "R5");
      send(5'd6, 16'h0, 16'h0, 8'h80, 8'h00, 16'h4000, 4'd8, "R5");
      send(5'd6, 16'h0, 16'h0, 8'h12, 8'h34, 16'h0020, 4'd3, "R5");
      send(5'd6, 16'h0, 16'h0, 8'hFF, 8'hFD, 16'h0020, 4'd3, "R5");
      // R3 target splits into aligned base and pointer
      send(5'd5, 16'h0, 16'h0, 8'h0B, 8'h00, 16'h0FFC, 4'd6, "R3");
      // R6 equality against second word
      send(5'd7, 16'h1234, 16'h1234, 8'h10, 8'h00, 16'h0200, 4'd2, "R6");
      send(5'd7, 16'h1234, 16'h1235, 8'h10, 8'h00, 16'h0200, 4'd2, "R6");
      send(5'd8, 16'h1234, 16'h1235, 8'hF0, 8'h00, 16'h0200, 4'd2, "R6");
      send(5'd8, 16'hFFFF, 16'hFFFF, 8'hF0, 8'h00, 16'h0200, 4'd2, "R6");
      // R7 immediate equality, beta displacement
      send(5'd9,  16'h0041, 16'h0, 8'h41, 8'hF0, 16'h0300, 4'd3, "R7");
      send(5'd9,  16'h0141, 16'h0, 8'h41, 8'hF0, 16'h0300, 4'd3, "R7");
      send(5'd10, 16'h0141, 16'h0, 8'h41, 8'h05, 16'h0300, 4'd8, "R7");
      // R8 signed compares incl. overflow
      send(5'd11, 16'h0001, 16'h8000, 8'h04, 8'h00, 16'h0400, 4'd2, "R8");
      send(5'd11, 16'h8000, 16'h0001, 8'h04, 8'h00, 16'h0400, 4'd2, "R8");
      send(5'd12, 16'h0005, 16'h0005, 8'h04, 8'h00, 16'h0400, 4'd2, "R8");
      send(5'd12, 16'h7FFF, 16'h8000, 8'h04, 8'h00, 16'h0400, 4'd2, "R8");
      send(5'd13, 16'hFFFF, 16'h7FFF, 8'h04, 8'h00, 16'h0400, 4'd2, "R8");
      send(5'd13, 16'h0005, 16'h0005, 8'h04, 8'h00, 16'h0400, 4'd2, "R8");
      send(5'd14, 16'h0005, 16'h0005, 8'hFC, 8'h00, 16'h0400, 4'd2, "R8");
      send(5'd14, 16'h8000, 16'h7FFF, 8'hFC, 8'h00, 16'h0400, 4'd2, "R8");
      // R9 unsigned compares
      send(5'd15, 16'h0001, 16'h8000, 8'h04, 8'h00, 16'h0500, 4'd4, "R9");
      send(5'd15, 16'hFFFF, 16'h7FFF, 8'h04, 8'h00, 16'h0500, 4'd4, "R9");
      send(5'd16, 16'h0009, 16'h0009, 8'h04, 8'h00, 16'h0500, 4'd4, "R9");
      send(5'd17, 16'h0009, 16'h0009, 8'h04, 8'h00, 16'h0500, 4'd4, "R9");
      send(5'd17, 16'h0001, 16'hFFFF, 8'h04, 8'h00, 16'h0500, 4'd4, "R9");
      send(5'd18, 16'h0009, 16'h0009, 8'h04, 8'h00, 16'h0500, 4'd4, "R9");
      // R10 zero tests
      send(5'd19, 16'h0000, 16'h0, 8'h00, 8'h00, 16'h0600, 4'd6, "R10");
      send(5'd20, 16'h0001, 16'h0, 8'h00, 8'h00, 16'h0600, 4'd6, "R10");
      send(5'd21, 16'h0000, 16'h0, 8'hE0, 8'h00, 16'h0600, 4'd6, "R10");
      send(5'd22, 16'h0100, 16'h0, 8'h00, 8'h00, 16'h0600, 4'd6, "R10");
      send(5'd23, 16'h0000, 16'h0, 8'h00, 8'h00, 16'h0600, 4'd8, "R10");
      send(5'd24, 16'h8000, 16'h0, 8'h22, 8'h00, 16'h0600, 4'd6, "R10");
      // R11 nibble pair
      send(5'd25, 16'h0003, 16'h0, 8'h35, 8'h00, 16'h0700, 4'd2, "R11");
      send(5'd25, 16'h0013, 16'h0, 8'h35, 8'h00, 16'h0700, 4'd2, "R11");
      send(5'd26, 16'h0013, 16'h0, 8'h3F, 8'h00, 16'h0700, 4'd7, "R11");
      // R12 fall-through with pointer at end of quadword
      send(5'd7, 16'h0001, 16'h0002, 8'h80, 8'h00, 16'hFFFC, 4'd8, "R12");
      send(5'd9, 16'h0001, 16'h0, 8'h02, 8'h80, 16'h0800, 4'd3, "R12");
      // R13 undefined codes
      send(5'd27, 16'h0, 16'h0, 8'h10, 8'h10, 16'h0900, 4'd4, "R13");
      send(5'd31, 16'h0, 16'h0, 8'h10, 8'h10, 16'h0900, 4'd8, "R13");

      // mixed stream over all codes
      for (int i = 0; i < 120; i++) begin
         logic [15:0] t, n;
         logic [4:0]  op;
         logic [3:0]  p;
         lfsr = step(lfsr); op = 5'(lfsr % 32);
         lfsr = step(lfsr); t = lfsr[15:0]; n = lfsr[31] ? t : lfsr[31:16];
         lfsr = step(lfsr); p = 4'(lfsr % 9);
         if (lfsr[20]) t = lfsr[19] ? 16'h0 : {12'h000, lfsr[27:24]};
         send(op, t, n, lfsr[7:0], lfsr[15:8], {lfsr[31:18], 2'b00}, p, "R3");
      end

      repeat (3) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R2: %0d results never reported, expected 0", sb.size());
      end
      report();
   end

endmodule